// File: doc/BRIEF.md
# TLB Access Permission Checker

This block judges one memory access against the single translation entry that has already matched it. It decides whether the access is granted, held in a stall, reported as a miss, or faulted. The inputs are the access kind (instruction fetch, data load or data store), the page-offset address, a speculative flag and a cancel strobe. The entry supplies a 4-bit subpage validity mask, a change bit, a guarded bit, cache-inhibit and write-through bits, and a valid bit. Separate subpage-mode selects for the instruction side and the data side control whether the mask is checked.

A request is captured on a clock edge while `req_valid_i` is high. Its outcome appears in the cycle after that edge. All outcomes except the stall last exactly one cycle. A stall holds the captured request and stays asserted. While it is held, the block re-samples `spec_i` and `cancel_i` on each edge until one of them resolves the stall. The invalidate strobe tells the surrounding TLB to drop the entry when a store hits an unmodified page. The cache attributes leave the block alongside the outcome.

Top module: `tlb_perm_check`

## Requirements
- R1: The subpage index is offset bits [11:10]. Index 0 (offsets 0x000–0x3FF) is governed by mask bit 3 and index 3 by mask bit 0. When subpage mode is on for the access's side and the selected mask bit is 0, the outcome is a miss.
- R2: Paired masks give 2KB pages. Mask 0b1100 admits offsets 0x000–0x7FF and misses on 0x800–0xFFF. Mask 0b0011 admits the reverse.
- R3: Fetches (acc code 0) use `isub_en_i`. Loads (code 1), stores (code 2) and code 3 (treated as a load) use `dsub_en_i`. With the side's mode off, the mask has no effect on the outcome.
- R4: An entry with `ent_valid_i`=0 produces a miss.
- R5: A fetch to a guarded page produces a one-cycle `ierr_o` and no grant, whether or not the fetch is speculative.
- R6: A store to a page whose change bit is 0 produces `derr_o` and `inval_o` together for one cycle. A load to such a page is granted.
- R7: A speculative load or store to a guarded page asserts `stall_o`. The stall stays asserted while `spec_i` stays 1 and `cancel_i` stays 0.
- R8: A stall resolves on the next edge. If `spec_i` is 0 there, the next cycle shows a grant. If `cancel_i` is 1 there, the stall drops with no grant, and cancel wins over a simultaneous `spec_i`=0.
- R9: Priority is miss, then fetch guard error, then write-protect error, then stall, then grant. At most one of grant, stall, miss, ierr and derr is high in any cycle.
- R10: `ci_o` and `wt_o` carry the captured entry's attributes in every cycle that shows an outcome, and are 0 otherwise.
- R11: `mode_err_o` is high in the cycle after the edge on which `isub_en_i` and `dsub_en_i` differ.
- R12: A request offered while `stall_o` is high is ignored. Otherwise requests are accepted on consecutive edges, with one outcome per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Capture a request on this edge |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| off_i | input | OFF_W | Page-offset address |
| spec_i | input | 1 | Access is speculative |
| cancel_i | input | 1 | Core abandons a stalled access |
| ent_valid_i | input | 1 | Entry valid |
| ent_mask_i | input | SUBPG_N | Subpage validity mask |
| ent_chg_i | input | 1 | Change bit; 0 write-protects |
| ent_grd_i | input | 1 | Guarded page |
| ent_ci_i | input | 1 | Cache inhibit |
| ent_wt_i | input | 1 | Write-through |
| isub_en_i | input | 1 | Subpage mode, instruction side |
| dsub_en_i | input | 1 | Subpage mode, data side |
| grant_o | output | 1 | Access proceeds |
| stall_o | output | 1 | Access held |
| miss_o | output | 1 | Translation miss |
| ierr_o | output | 1 | Instruction-side TLB error |
| derr_o | output | 1 | Data-side TLB error |
| inval_o | output | 1 | Invalidate the matched entry |
| ci_o | output | 1 | Cache inhibit of the current outcome |
| wt_o | output | 1 | Write-through of the current outcome |
| mode_err_o | output | 1 | Illegal subpage-mode combination |

## Verification
The hardest situation to reach is the end of a held stall. The outcome depends on the values of `spec_i` and `cancel_i` at the precise edge after the stall appears. It also matters that a competing request offered during the stall must vanish without trace. The stimulus first parks a speculative guarded load in the stall. It then steps the stall one cycle at a time: it keeps the speculative flag high for several edges, offers a stray store during the hold, and ends either by clearing the flag, by cancelling, or by doing both on the same edge. The scoreboard expects exactly one stall entry per held cycle and nothing after a cancel.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    OUT_NONE,
    OUT_GRANT,
    OUT_STALL,
    OUT_MISS,
    OUT_IERR,
    OUT_DERR
  } outcome_e;

  typedef struct packed {
    acc_e acc;
    logic spec;
    logic valid;
    logic chg;
    logic grd;
    logic ci;
    logic wt;
  } req_t;
endpackage

// File: rtl/tlb_req_reg.sv
module tlb_req_reg
  import tlb_perm_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int SUBPG_N = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  req_t               req_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [SUBPG_N-1:0] mask_i,
  input  logic               hold_i,
  input  logic               spec_i,
  input  logic               cancel_i,
  input  logic               isub_i,
  input  logic               dsub_i,
  output logic               busy_o,
  output req_t               req_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [SUBPG_N-1:0] mask_o,
  output logic               isub_o,
  output logic               dsub_o
);
  logic accept;
  assign accept = req_valid_i & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      req_o  <= '0;
      off_o  <= '0;
      mask_o <= '0;
    end else if (accept) begin
      busy_o <= 1'b1;
      req_o  <= req_i;
      off_o  <= off_i;
      mask_o <= mask_i;
    end else if (hold_i) begin
      // stalled: cancel frees, else track speculation
      if (cancel_i) busy_o <= 1'b0;
      else          req_o.spec <= spec_i;
    end else begin
      busy_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isub_o <= 1'b0;
      dsub_o <= 1'b0;
    end else begin
      isub_o <= isub_i;
      dsub_o <= dsub_i;
    end
  end
endmodule

// File: rtl/tlb_subpg_chk.sv
module tlb_subpg_chk #(
  parameter int OFF_W   = 12,
  parameter int SUBPG_N = 4
) (
  input  logic [OFF_W-1:0]   off_i,
  input  logic [SUBPG_N-1:0] mask_i,
  input  logic               en_i,
  output logic               hit_o
);
  localparam int IDX_W = $clog2(SUBPG_N);

  logic [IDX_W-1:0] idx;
  logic             sel;

  assign idx = off_i[OFF_W-1 -: IDX_W];

  // lowest-address subpage sits on the mask MSB
  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < SUBPG_N; i++) begin
      if (idx == IDX_W'(i)) sel = mask_i[SUBPG_N-1-i];
    end
  end

  assign hit_o = ~en_i | sel;
endmodule

// File: rtl/tlb_perm_arb.sv
module tlb_perm_arb
  import tlb_perm_pkg::*;
(
  input  logic     busy_i,
  input  req_t     req_i,
  input  logic     sub_hit_i,
  output outcome_e out_o
);
  logic is_fetch, is_store;
  assign is_fetch = (req_i.acc == ACC_FETCH);
  assign is_store = (req_i.acc == ACC_STORE);

  always_comb begin
    if (!busy_i)                          out_o = OUT_NONE;
    else if (!req_i.valid || !sub_hit_i)  out_o = OUT_MISS;
    else if (is_fetch && req_i.grd)       out_o = OUT_IERR;
    else if (is_store && !req_i.chg)      out_o = OUT_DERR;
    else if (req_i.spec && req_i.grd)     out_o = OUT_STALL;
    else                                  out_o = OUT_GRANT;
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_perm_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int SUBPG_N = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         acc_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               spec_i,
  input  logic               cancel_i,
  input  logic               ent_valid_i,
  input  logic [SUBPG_N-1:0] ent_mask_i,
  input  logic               ent_chg_i,
  input  logic               ent_grd_i,
  input  logic               ent_ci_i,
  input  logic               ent_wt_i,
  input  logic               isub_en_i,
  input  logic               dsub_en_i,
  output logic               grant_o,
  output logic               stall_o,
  output logic               miss_o,
  output logic               ierr_o,
  output logic               derr_o,
  output logic               inval_o,
  output logic               ci_o,
  output logic               wt_o,
  output logic               mode_err_o
);
  req_t               req_in, req_q;
  logic [OFF_W-1:0]   off_q;
  logic [SUBPG_N-1:0] mask_q;
  logic               busy_q, isub_q, dsub_q;
  logic               sub_en, sub_hit;
  outcome_e           outcome;

  assign req_in = '{acc:   acc_e'(acc_i),
                    spec:  spec_i,
                    valid: ent_valid_i,
                    chg:   ent_chg_i,
                    grd:   ent_grd_i,
                    ci:    ent_ci_i,
                    wt:    ent_wt_i};

  tlb_req_reg #(.OFF_W(OFF_W), .SUBPG_N(SUBPG_N)) i_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_i       (req_in),
    .off_i       (off_i),
    .mask_i      (ent_mask_i),
    .hold_i      (stall_o),
    .spec_i      (spec_i),
    .cancel_i    (cancel_i),
    .isub_i      (isub_en_i),
    .dsub_i      (dsub_en_i),
    .busy_o      (busy_q),
    .req_o       (req_q),
    .off_o       (off_q),
    .mask_o      (mask_q),
    .isub_o      (isub_q),
    .dsub_o      (dsub_q)
  );

  assign sub_en = (req_q.acc == ACC_FETCH) ? isub_q : dsub_q;

  tlb_subpg_chk #(.OFF_W(OFF_W), .SUBPG_N(SUBPG_N)) i_sub (
    .off_i  (off_q),
    .mask_i (mask_q),
    .en_i   (sub_en),
    .hit_o  (sub_hit)
  );

  tlb_perm_arb i_arb (
    .busy_i    (busy_q),
    .req_i     (req_q),
    .sub_hit_i (sub_hit),
    .out_o     (outcome)
  );

  assign grant_o    = (outcome == OUT_GRANT);
  assign stall_o    = (outcome == OUT_STALL);
  assign miss_o     = (outcome == OUT_MISS);
  assign ierr_o     = (outcome == OUT_IERR);
  assign derr_o     = (outcome == OUT_DERR);
  assign inval_o    = derr_o;
  assign ci_o       = busy_q & req_q.ci;
  assign wt_o       = busy_q & req_q.wt;
  assign mode_err_o = isub_q ^ dsub_q;
endmodule

// File: rtl/tlb_perm_sva.sv
module tlb_perm_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic spec_i,
  input logic cancel_i,
  input logic grant_o,
  input logic stall_o,
  input logic miss_o,
  input logic ierr_o,
  input logic derr_o,
  input logic inval_o,
  input logic ci_o,
  input logic wt_o
);
  logic any_out;
  assign any_out = grant_o | stall_o | miss_o | ierr_o | derr_o;

  a_r9_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, stall_o, miss_o, ierr_o, derr_o}));

  a_r6_derr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    derr_o && !req_valid_i |=> !derr_o && !inval_o);

  a_r5_ierr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ierr_o && !req_valid_i |=> !ierr_o);

  a_r7_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && spec_i && !cancel_i |=> stall_o);

  a_r8_release_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && !spec_i && !cancel_i |=> grant_o);

  a_r8_cancel_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && cancel_i |=> !stall_o && !grant_o);

  a_r10_attr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_out |-> !ci_o && !wt_o);
endmodule

bind tlb_perm_check tlb_perm_sva i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .spec_i      (spec_i),
  .cancel_i    (cancel_i),
  .grant_o     (grant_o),
  .stall_o     (stall_o),
  .miss_o      (miss_o),
  .ierr_o      (ierr_o),
  .derr_o      (derr_o),
  .inval_o     (inval_o),
  .ci_o        (ci_o),
  .wt_o        (wt_o)
);

// File: tb/test_tlb_perm_check.sv
`timescale 1ns/1ps
module test_tlb_perm_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  acc_i = '0;
  logic [11:0] off_i = '0;
  logic        spec_i = 1'b0, cancel_i = 1'b0;
  logic        ent_valid_i = 1'b0, ent_chg_i = 1'b0, ent_grd_i = 1'b0;
  logic        ent_ci_i = 1'b0, ent_wt_i = 1'b0;
  logic [3:0]  ent_mask_i = '0;
  logic        isub_en_i = 1'b0, dsub_en_i = 1'b0;
  logic        grant_o, stall_o, miss_o, ierr_o, derr_o, inval_o, ci_o, wt_o, mode_err_o;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [7:0] V_GRANT = 8'b1000_0000;
  localparam logic [7:0] V_STALL = 8'b0100_0000;
  localparam logic [7:0] V_MISS  = 8'b0010_0000;
  localparam logic [7:0] V_IERR  = 8'b0001_0000;
  localparam logic [7:0] V_DERR  = 8'b0000_1100;

  always #5 clk_i = ~clk_i;

  tlb_perm_check i_tlb_perm_check (.*);

  wire [7:0] obs = {grant_o, stall_o, miss_o, ierr_o, derr_o, inval_o, ci_o, wt_o};

  // model built from the requirement list
  function automatic logic [7:0] predict(logic [1:0] acc, logic [11:0] off, logic spec,
                                         logic v, logic [3:0] m, logic chg, logic grd,
                                         logic ci, logic wt, logic isub, logic dsub);
    logic en, bitv;
    logic [7:0] r;
    en   = (acc == 2'd0) ? isub : dsub;
    bitv = m[3 - off[11:10]];
    if (!v || (en && !bitv))       r = V_MISS;
    else if (acc == 2'd0 && grd)   r = V_IERR;
    else if (acc == 2'd2 && !chg)  r = V_DERR;
    else if (acc != 2'd0 && spec && grd) r = V_STALL;
    else                           r = V_GRANT;
    return r | {6'b0, ci, wt};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pop one expectation per cycle that shows an outcome
  always @(negedge clk_i) begin
    if (rst_ni && (obs[7:3] != 5'b0)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12 unexpected outcome", obs, 8'h00);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(obs == e.v, e.tag, obs, e.v);
      end
    end
  end

  // driver: present a request for one edge, predict its outcome
  task automatic send(input logic [1:0] acc, input logic [11:0] off, input logic spec,
                      input logic v, input logic [3:0] m, input logic chg, input logic grd,
                      input logic ci, input logic wt, input string tag);
    exp_t e;
    req_valid_i = 1'b1; acc_i = acc; off_i = off; spec_i = spec; cancel_i = 1'b0;
    ent_valid_i = v; ent_mask_i = m; ent_chg_i = chg; ent_grd_i = grd;
    ent_ci_i = ci; ent_wt_i = wt;
    e.v = predict(acc, off, spec, v, m, chg, grd, ci, wt, isub_en_i, dsub_en_i);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  // one cycle of a held stall
  task automatic step(input logic spec, input logic cancel, input logic stray,
                      input logic push, input logic [7:0] v, input string tag);
    exp_t e;
    req_valid_i = stray;
    if (stray) begin acc_i = 2'd2; ent_chg_i = 1'b0; ent_grd_i = 1'b0; end
    spec_i = spec; cancel_i = cancel;
    if (push) begin e.v = v; e.tag = tag; sb.push_back(e); end
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    req_valid_i = 1'b0; spec_i = 1'b0; cancel_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", 8'h00, 8'h00);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(obs == 8'h00 && !mode_err_o, "reset state", obs, 8'h00);
    rst_ni = 1'b1;
    isub_en_i = 1'b1; dsub_en_i = 1'b1;
    idle(2);
    check(!mode_err_o, "R11 legal modes", {7'b0, mode_err_o}, 8'h00);

    // R1 single 1KB subpages
    send(2'd1, 12'h000, 0, 1, 4'b1000, 1, 0, 0, 0, "R1 first subpage hit");
    send(2'd1, 12'h400, 0, 1, 4'b1000, 1, 0, 0, 0, "R1 second subpage miss");
    send(2'd1, 12'hC00, 0, 1, 4'b0001, 1, 0, 0, 0, "R1 fourth subpage hit");
    send(2'd0, 12'h3FF, 0, 1, 4'b0001, 1, 0, 0, 0, "R1 fetch first subpage miss");
    send(2'd0, 12'h800, 0, 1, 4'b0010, 1, 0, 0, 0, "R1 fetch third subpage hit");
    // R2 paired 2KB
    send(2'd2, 12'h7FF, 0, 1, 4'b1100, 1, 0, 0, 0, "R2 lower half hit");
    send(2'd2, 12'h800, 0, 1, 4'b1100, 1, 0, 0, 0, "R2 lower mask upper miss");
    send(2'd1, 12'hFFC, 0, 1, 4'b0011, 1, 0, 0, 0, "R2 upper half hit");
    send(2'd1, 12'h000, 0, 1, 4'b0011, 1, 0, 0, 0, "R2 upper mask lower miss");
    // R4
    send(2'd1, 12'h000, 0, 0, 4'b1111, 1, 0, 0, 0, "R4 invalid entry miss");
    // R5
    send(2'd0, 12'h100, 0, 1, 4'b1111, 1, 1, 0, 0, "R5 guarded fetch error");
    send(2'd0, 12'h100, 1, 1, 4'b1111, 1, 1, 0, 0, "R5 speculative guarded fetch error");
    send(2'd0, 12'h500, 0, 1, 4'b1000, 1, 1, 0, 0, "R9 miss beats guarded fetch");
    send(2'd0, 12'h100, 1, 1, 4'b1111, 1, 0, 0, 0, "R9 speculative unguarded fetch grant");
    // R6
    send(2'd2, 12'h200, 0, 1, 4'b1111, 0, 0, 0, 0, "R6 store unmodified error");
    send(2'd1, 12'h200, 0, 1, 4'b1111, 0, 0, 0, 0, "R6 load unmodified grant");
    send(2'd2, 12'h200, 1, 1, 4'b1111, 0, 1, 0, 0, "R9 write-protect beats stall");
    send(2'd3, 12'h200, 0, 1, 4'b1111, 0, 0, 0, 0, "R3 code 3 acts as load");
    // R10
    send(2'd1, 12'h000, 0, 1, 4'b1111, 1, 0, 1, 0, "R10 ci on grant");
    send(2'd1, 12'h400, 0, 1, 4'b1000, 1, 0, 0, 1, "R10 wt on miss");
    send(2'd2, 12'h000, 0, 1, 4'b1111, 0, 0, 1, 1, "R10 attrs on error");
    idle(2);

    // R7/R8 stall then release
    send(2'd1, 12'h000, 1, 1, 4'b1111, 1, 1, 0, 0, "R7 speculative guarded load stall");
    step(1, 0, 0, 1, V_STALL, "R7 stall held 1");
    step(1, 0, 0, 1, V_STALL, "R7 stall held 2");
    step(0, 0, 0, 1, V_GRANT, "R8 release grants");
    idle(2);
    // stall then cancel
    send(2'd2, 12'h000, 1, 1, 4'b1111, 1, 1, 0, 0, "R7 speculative guarded store stall");
    step(1, 0, 0, 1, V_STALL, "R7 store stall held");
    step(1, 1, 0, 0, 8'h00, "");
    idle(3);
    // cancel wins over simultaneous release
    send(2'd1, 12'h000, 1, 1, 4'b1111, 1, 1, 0, 0, "R7 stall before cancel race");
    step(0, 1, 0, 0, 8'h00, "");
    idle(3);
    // R12 stray request during stall ignored
    send(2'd1, 12'h000, 1, 1, 4'b1111, 1, 1, 0, 0, "R12 stall start");
    step(1, 0, 1, 1, V_STALL, "R12 stray request ignored");
    step(0, 0, 0, 1, V_GRANT, "R12 grant after stray");
    idle(3);

    // R3 modes off: mask ignored
    isub_en_i = 1'b0; dsub_en_i = 1'b0;
    idle(1);
    send(2'd1, 12'h400, 0, 1, 4'b0000, 1, 0, 0, 0, "R3 data mode off mask ignored");
    send(2'd0, 12'hC00, 0, 1, 4'b0000, 1, 0, 0, 0, "R3 fetch mode off mask ignored");
    idle(2);
    // R11 illegal combination, per-side enable
    isub_en_i = 1'b0; dsub_en_i = 1'b1;
    idle(1);
    check(mode_err_o, "R11 illegal modes flagged", {7'b0, mode_err_o}, 8'h01);
    send(2'd0, 12'h000, 0, 1, 4'b0000, 1, 0, 0, 0, "R3 fetch side off");
    send(2'd1, 12'h000, 0, 1, 4'b0000, 1, 0, 0, 0, "R3 data side on");
    isub_en_i = 1'b1; dsub_en_i = 1'b0;
    idle(1);
    check(mode_err_o, "R11 reverse illegal flagged", {7'b0, mode_err_o}, 8'h01);
    isub_en_i = 1'b1; dsub_en_i = 1'b1;
    idle(1);
    check(!mode_err_o, "R11 flag clears", {7'b0, mode_err_o}, 8'h00);
    idle(3);
    check(sb.size() == 0, "R12 all outcomes seen", 8'(sb.size()), 8'h00);
    finish_run();
  end
endmodule